// File: doc/BRIEF.md
# Power-of-Two Input Debounce Filter

This block cleans up one general-purpose input line before the line reaches the input-status register and the edge-interrupt detector. The raw pin passes first through a multi-flop synchroniser. An enable bit and a 3-bit exponent control the filter. When the filter is enabled, its output moves to a new level only after the synchronised input has held that level for 2^N ticks of an external millisecond strobe. That gives a period of 1 to 128 ms. When the filter is disabled, the synchronised level goes to the output through a single register.

The exponent and enable inputs are meant to be wired to bits 7:5 and bit 8 of the pin's control word. Software clears bit 8 to select zero debounce time. To set a time, software rounds the requested time to the nearest power of two and writes its exponent. The millisecond strobe comes from outside the block.

Top module: `gpio_debounce`

## Requirements
- R1: When `db_en` is 0, `pin_filt` equals the value `pin_in` had three clock edges earlier: two synchroniser flops, then the output register.
- R2: When `db_en` is 1, `pin_filt` takes the new level on the clock edge that samples the 2^N-th asserted `ms_tick` during which the synchronised input continuously differed from `pin_filt`, where N is `db_exp` (0 to 7, giving 1 to 128 ms). After 2^N-1 such ticks, the output still holds the old level.
- R3: If the synchronised input returns to the `pin_filt` level before the count completes, the count restarts from zero and the output does not change.
- R4: With the filter enabled, the output never changes on a cycle without `ms_tick`, however long the new level is held.
- R5: Any change of `db_en` or `db_exp` clears the tick count. On the edge that sees the change, `pin_filt` keeps its value.
- R6: During reset `pin_filt` is 0. After reset is released, `pin_filt` loads the first fully synchronised sample on the third clock edge, without waiting for a debounce count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle millisecond strobe |
| pin_in | input | 1 | Raw, asynchronous pin level |
| db_en | input | 1 | Debounce enable (control word bit 8) |
| db_exp | input | 3 | Period exponent N, period 2^N ms (control word bits 7:5) |
| pin_filt | output | 1 | Filtered level |

## Verification
A tick count that is wrong by even one shows up at `pin_filt` as an edge one strobe early or one strobe late. The sweep over every exponent in both directions therefore checks the output just before the final strobe and just after it. A count that is not cleared on a bounce or on a configuration write produces an early transition within the same window. A broken bypass path or a broken start-up load gives a wrong level within three clocks of the stimulus.

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
  parameter int SYNC_STAGES = 2,
  parameter int EXP_W       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ms_tick,
  input  logic             pin_in,
  input  logic             db_en,
  input  logic [EXP_W-1:0] db_exp,
  output logic             pin_filt
);

  localparam int MAX_EXP = (1 << EXP_W) - 1;
  localparam int CNT_W   = MAX_EXP + 2;
  localparam int FILL_W  = $clog2(SYNC_STAGES + 2);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILL_W-1:0]      fill_q;
  logic [EXP_W:0]         cfg_q;
  logic [CNT_W-1:0]       cnt_q;
  logic [CNT_W-1:0]       period;
  logic [CNT_W-1:0]       cnt_nxt;
  logic                   pin_s;
  logic                   primed;
  logic                   cfg_chg;

  assign pin_s   = sync_q[SYNC_STAGES-1];
  assign primed  = (fill_q == FILL_W'(SYNC_STAGES + 1));
  assign cfg_chg = (cfg_q != {db_en, db_exp});
  assign period  = CNT_W'(1) << db_exp;
  assign cnt_nxt = cnt_q + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '0;
      fill_q   <= '0;
      cfg_q    <= '0;
      cnt_q    <= '0;
      pin_filt <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_in};
      cfg_q  <= {db_en, db_exp};
      if (!primed) begin
        if (fill_q == FILL_W'(SYNC_STAGES)) pin_filt <= pin_s;
        fill_q <= fill_q + FILL_W'(1);
      end else if (cfg_chg) begin
        cnt_q <= '0;
      end else if (!db_en) begin
        pin_filt <= pin_s;
        cnt_q    <= '0;
      end else if (pin_s == pin_filt) begin
        cnt_q <= '0;
      end else if (ms_tick) begin
        if (cnt_nxt == period) begin
          pin_filt <= pin_s;
          cnt_q    <= '0;
        end else begin
          cnt_q <= cnt_nxt;
        end
      end
    end
  end

  logic             ps_q;
  logic [CNT_W:0]   chk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q  <= 1'b0;
      chk_q <= '0;
    end else begin
      ps_q <= pin_s;
      if (pin_s != ps_q)        chk_q <= {{CNT_W{1'b0}}, ms_tick};
      else if (cfg_chg)         chk_q <= '0;
      else if (ms_tick && !(&chk_q)) chk_q <= chk_q + 1'b1;
    end
  end

  a_r1_follow_sample: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(primed) && pin_filt != $past(pin_filt)) |-> pin_filt == $past(pin_s));

  a_r4_move_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(primed) && $past(db_en) && pin_filt != $past(pin_filt)) |-> $past(ms_tick));

  a_r2_full_window: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(primed) && $past(db_en) && pin_filt != $past(pin_filt))
      |-> chk_q >= {1'b0, $past(period)});

  a_r5_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(primed) && $past({db_en, db_exp}) != $past({db_en, db_exp}, 2))
      |-> pin_filt == $past(pin_filt));

  always @(negedge clk) begin
    if (!rst_n) a_r6_reset_low: assert (pin_filt == 1'b0);
  end

endmodule

// File: tb/gpio_debounce_tb.sv
`timescale 1ns/1ps
module gpio_debounce_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ms_tick = 1'b0;
  logic       pin_in = 1'b0;
  logic       db_en = 1'b0;
  logic [2:0] db_exp = 3'd0;
  logic       pin_filt;
  int         n_chk = 0;
  int         n_bad = 0;
  logic       hist [0:63];

  always #2.5 clk = ~clk;

  gpio_debounce dut_i (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .pin_in(pin_in),
    .db_en(db_en), .db_exp(db_exp), .pin_filt(pin_filt)
  );

  task automatic check(input logic got, input logic exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: pin_filt=%0b expected=%0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk) ms_tick = 1'b1;
    @(negedge clk) ms_tick = 1'b0;
  endtask

  task automatic set_pin(input logic v);
    @(negedge clk) pin_in = v;
    settle(3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic lvl;
    pin_in = 1'b1;
    db_en  = 1'b1;
    settle(2);
    check(pin_filt, 1'b0, "R6 in reset");
    rst_n = 1'b1;
    settle(2);
    check(pin_filt, 1'b0, "R6 before load");
    settle(1);
    check(pin_filt, 1'b1, "R6 first sample");
    settle(3);

    // R2: every exponent, both directions
    for (int n = 0; n < 8; n++) begin
      @(negedge clk) db_exp = 3'(n);
      settle(3);
      for (int d = 0; d < 2; d++) begin
        lvl = pin_filt;
        set_pin(~lvl);
        for (int k = 1; k <= (1 << n); k++) begin
          tick();
          if (k < (1 << n)) check(pin_filt, lvl, "R2 before period");
          else              check(pin_filt, ~lvl, "R2 at period");
        end
      end
    end

    // R3: bounce restarts the count (N=2)
    @(negedge clk) db_exp = 3'd2;
    settle(3);
    lvl = pin_filt;
    set_pin(~lvl);
    repeat (3) tick();
    set_pin(lvl);
    check(pin_filt, lvl, "R3 bounce ignored");
    set_pin(~lvl);
    repeat (3) tick();
    check(pin_filt, lvl, "R3 restart");
    tick();
    check(pin_filt, ~lvl, "R3 after full count");

    // R4: no tick, no change (N=0)
    @(negedge clk) db_exp = 3'd0;
    settle(3);
    lvl = pin_filt;
    set_pin(~lvl);
    settle(50);
    check(pin_filt, lvl, "R4 held without tick");
    tick();
    check(pin_filt, ~lvl, "R4 one tick");

    // R5: exponent change clears the count
    @(negedge clk) db_exp = 3'd3;
    settle(3);
    lvl = pin_filt;
    set_pin(~lvl);
    repeat (5) tick();
    @(negedge clk) db_exp = 3'd2;
    settle(1);
    check(pin_filt, lvl, "R5 hold on change");
    repeat (3) tick();
    check(pin_filt, lvl, "R5 count cleared");
    tick();
    check(pin_filt, ~lvl, "R5 new period");

    // R1: bypass follows input three edges later
    @(negedge clk) db_en = 1'b0;
    settle(3);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (i >= 3) check(pin_filt, hist[i-3], "R1 bypass");
      hist[i] = ((i * 7 + 3) % 5) < 2;
      pin_in = hist[i];
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule